// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour only), day of month, month, two-digit year standing for 2000–2099, and a day-of-week counter. A one-cycle enable, `tick_i`, pulses at the slow oscillator rate (32768 per second by default). A divider counts these pulses and advances the calendar once per second. The carries run from seconds to years in one update, and the day limit follows the month and the leap-year rule.

Software uses a byte-wide register bus with word-spaced offsets. It can read and write every time field, six alarm fields, a control register, a status register and an interrupt-enable register. An alarm fires only when all six alarm fields equal the time. No field is a wildcard. One divider period before each update the status register shows a busy flag. Software polls it to find a safe access window. When software writes a time field, the divider restarts, so the next update comes one full second after that write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 0. Control, status and interrupt-enable read 0x00, and both interrupt outputs are low.
- R2: Register map, with byte offsets and the two low address bits required to be zero. Time fields sit at 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year, 0x18 weekday. Alarm fields sit at 0x20–0x34 in the same order without weekday. Control is at 0x40, status at 0x44, interrupt-enable at 0x48. Written values are masked to 0x7F, 0x7F, 0x3F, 0x3F, 0x1F, 0xFF and 0x07 for the time fields, and the alarm fields use the same masks. Control keeps bit 0 only and interrupt-enable keeps bits 2 and 3 only. Any other address reads 0x00.
- R3: Control bit 0 set to 1 runs the clock, and status bit 1 mirrors it. While it is 0 the time does not change and status bit 0 stays 0.
- R4: While running, the calendar advances by one second on every TICKS_PER_SEC-th tick. A write to any time field restarts the divider, so the next update happens on exactly the TICKS_PER_SEC-th tick after that write.
- R5: Status bit 0 (busy) is 1 during the last tick interval before an update, meaning TICKS_PER_SEC-1 ticks have been counted since the last update or restart. It is 0 otherwise.
- R6: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00. Each wrap carries into the next field in the same update.
- R7: The day wraps to 01 after 28, 29, 30 or 31 according to the month. February has 29 days when the year value is divisible by 4, year 00 included. Month wraps from 12 to 01 with a carry into the year, and the year wraps from 99 to 00. The weekday advances with each day change and wraps from 6 to 0.
- R8: Each update loads status bits 5..2 with {day changed, hour changed, minute changed, 1}.
- R9: Status bit 6 is set by an update whose new time equals all six alarm fields. It stays set until software writes the status register with bit 6 = 1. Writing 0 to bit 6 leaves it unchanged.
- R10: `irq_alarm_o` is high exactly while status bit 6 and interrupt-enable bit 3 are both 1.
- R11: When interrupt-enable bit 2 is 1, `irq_timer_o` pulses high for one clock cycle right after each update. When that bit is 0, `irq_timer_o` stays low.
- R12: A mismatch in any single alarm field keeps status bit 6 from being set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the oscillator rate |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_timer_o | output | 1 | One-cycle pulse per update when enabled |
| irq_alarm_o | output | 1 | Alarm interrupt level |

## Verification
A wrong carry or month-length decision shows at the ports in the same update that crosses the boundary: the time fields read back wrong one clock after the last tick. The bench therefore places many cases right at 59-second, 23-hour, month-end and leap-year boundaries. A divider phase error shows as the busy flag missing on the tick before the update, or as an update one tick early or late. An alarm compare fault shows as status bit 6 and `irq_alarm_o` going wrong on that same update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int N_TF   = 7;   // time fields incl. weekday
  localparam int N_AF   = 6;   // alarm fields
  localparam int FSEL_W = 3;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam logic [N_TF-1:0][7:0] FIELD_MASK =
    {8'h07, 8'hFF, 8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F};
  localparam logic [N_TF-1:0][7:0] TIME_RST =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // word indices (byte address >> 2)
  localparam int REG_ALM0 = 8;
  localparam int REG_CTRL = 16;
  localparam int REG_STAT = 17;
  localparam int REG_IEN  = 18;

  localparam int ST_BUSY  = 0;
  localparam int ST_RUN   = 1;
  localparam int ST_ALARM = 6;
  localparam int IE_TIMER = 2;
  localparam int IE_ALARM = 3;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 from BCD digits: tens parity picks the ones set
  function automatic logic leap_year(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic sec_stb_o,
  output logic busy_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  assign sec_stb_o = run_i && tick_i && last && !restart_i;
  assign busy_o    = run_i && last;

  AST_STB_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/rtc_cal_count.sv
module rtc_cal_count
  import rtc_cal_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  logic                   wr_en_i,
  input  logic [FSEL_W-1:0]      wr_sel_i,
  input  logic [7:0]             wr_data_i,
  output logic [N_TF-1:0][7:0]   cal_o,
  output logic [N_TF-1:0][7:0]   nxt_o,
  output logic [2:0]             roll_o
);
  logic [7:0] cal_q [N_TF];
  logic [7:0] nxt   [N_TF];
  logic c_sec, c_min, c_hr, c_day, c_mon;

  always_comb begin
    c_sec = (cal_q[F_SEC] == 8'h59);
    c_min = c_sec && (cal_q[F_MIN] == 8'h59);
    c_hr  = c_min && (cal_q[F_HOUR] == 8'h23);
    c_day = c_hr  && (cal_q[F_DAY] == last_day(cal_q[F_MON], cal_q[F_YEAR]));
    c_mon = c_day && (cal_q[F_MON] == 8'h12);

    nxt[F_SEC]  = c_sec ? 8'h00 : bcd_inc(cal_q[F_SEC]);
    nxt[F_MIN]  = c_min ? 8'h00 : (c_sec ? bcd_inc(cal_q[F_MIN])  : cal_q[F_MIN]);
    nxt[F_HOUR] = c_hr  ? 8'h00 : (c_min ? bcd_inc(cal_q[F_HOUR]) : cal_q[F_HOUR]);
    nxt[F_DAY]  = c_day ? 8'h01 : (c_hr  ? bcd_inc(cal_q[F_DAY])  : cal_q[F_DAY]);
    nxt[F_MON]  = c_mon ? 8'h01 : (c_day ? bcd_inc(cal_q[F_MON])  : cal_q[F_MON]);
    nxt[F_YEAR] = !c_mon ? cal_q[F_YEAR]
                : ((cal_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cal_q[F_YEAR]));
    nxt[F_WDAY] = !c_hr ? cal_q[F_WDAY]
                : ((cal_q[F_WDAY] >= 8'h06) ? 8'h00 : cal_q[F_WDAY] + 8'h01);
  end

  for (genvar f = 0; f < N_TF; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        cal_q[f] <= TIME_RST[f];
      else if (wr_en_i && (wr_sel_i == FSEL_W'(f)))       cal_q[f] <= wr_data_i & FIELD_MASK[f];
      else if (adv_i)                                     cal_q[f] <= nxt[f];
    end
    assign cal_o[f] = cal_q[f];
    assign nxt_o[f] = nxt[f];
  end

  assign roll_o = {c_hr, c_min, c_sec};

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && cal_q[F_SEC] == 8'h59) |=> (cal_q[F_SEC] == 8'h00)); // R6
  AST_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && cal_q[F_SEC] != 8'h59) |=> $stable(cal_q[F_MIN])); // R6
  AST_DAY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && cal_q[F_DAY] != 8'h00) |=> (cal_q[F_DAY] != 8'h00)); // R7
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [FSEL_W-1:0]    wr_sel_i,
  input  logic [7:0]           wr_data_i,
  input  logic [N_AF-1:0][7:0] cand_i,
  output logic [N_AF-1:0][7:0] alm_o,
  output logic                 match_o
);
  logic [7:0]      alm_q [N_AF];
  logic [N_AF-1:0] eq;

  for (genvar f = 0; f < N_AF; f++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  alm_q[f] <= 8'h00;
      else if (wr_en_i && (wr_sel_i == FSEL_W'(f))) alm_q[f] <= wr_data_i & FIELD_MASK[f];
    end
    assign eq[f]    = (alm_q[f] == cand_i[f]);
    assign alm_o[f] = alm_q[f];
  end

  // every field must agree, no wildcard
  assign match_o = &eq;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_timer_o,
  output logic              irq_alarm_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx, alm_off;
  logic             aligned, is_time, is_alarm, is_ctrl, is_stat, is_ien;
  logic             time_wr, alarm_wr, stat_wr;
  logic             run_q, alm_flag_q, irq_timer_q;
  logic [1:0]       ien_q;     // {alarm, timer}
  logic [3:0]       evt_q;     // {day, hour, minute, second}
  logic             sec_stb, busy, match;
  logic [2:0]       roll;
  logic [N_TF-1:0][7:0] cal_pk, nxt_pk;
  logic [N_AF-1:0][7:0] alm_pk;
  logic [7:0]       status;

  assign idx      = bus_addr_i[ADDR_W-1:2];
  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign alm_off  = idx - IDX_W'(REG_ALM0);
  assign is_time  = aligned && (idx < IDX_W'(N_TF));
  assign is_alarm = aligned && (idx >= IDX_W'(REG_ALM0)) && (idx < IDX_W'(REG_ALM0 + N_AF));
  assign is_ctrl  = aligned && (idx == IDX_W'(REG_CTRL));
  assign is_stat  = aligned && (idx == IDX_W'(REG_STAT));
  assign is_ien   = aligned && (idx == IDX_W'(REG_IEN));

  assign time_wr  = bus_we_i && is_time;
  assign alarm_wr = bus_we_i && is_alarm;
  assign stat_wr  = bus_we_i && is_stat;

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (time_wr),
    .tick_i    (tick_i),
    .sec_stb_o (sec_stb),
    .busy_o    (busy)
  );

  rtc_cal_count u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (sec_stb),
    .wr_en_i   (time_wr),
    .wr_sel_i  (idx[FSEL_W-1:0]),
    .wr_data_i (bus_wdata_i),
    .cal_o     (cal_pk),
    .nxt_o     (nxt_pk),
    .roll_o    (roll)
  );

  rtc_alarm_match u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (alarm_wr),
    .wr_sel_i  (alm_off[FSEL_W-1:0]),
    .wr_data_i (bus_wdata_i),
    .cand_i    (nxt_pk[N_AF-1:0]),
    .alm_o     (alm_pk),
    .match_o   (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      ien_q       <= 2'b00;
      evt_q       <= 4'h0;
      alm_flag_q  <= 1'b0;
      irq_timer_q <= 1'b0;
    end else begin
      if (bus_we_i && is_ctrl) run_q <= bus_wdata_i[0];
      if (bus_we_i && is_ien)  ien_q <= {bus_wdata_i[IE_ALARM], bus_wdata_i[IE_TIMER]};
      if (sec_stb)             evt_q <= {roll, 1'b1};
      // set wins over a same-cycle clear
      if (sec_stb && match)                     alm_flag_q <= 1'b1;
      else if (stat_wr && bus_wdata_i[ST_ALARM]) alm_flag_q <= 1'b0;
      irq_timer_q <= sec_stb && ien_q[0];
    end
  end

  assign status      = {1'b0, alm_flag_q, evt_q, run_q, busy};
  assign irq_timer_o = irq_timer_q;
  assign irq_alarm_o = alm_flag_q && ien_q[1];

  always_comb begin
    bus_rdata_o = 8'h00;
    if (is_time) begin
      for (int f = 0; f < N_TF; f++)
        if (idx[FSEL_W-1:0] == FSEL_W'(f)) bus_rdata_o = cal_pk[f];
    end else if (is_alarm) begin
      for (int f = 0; f < N_AF; f++)
        if (alm_off[FSEL_W-1:0] == FSEL_W'(f)) bus_rdata_o = alm_pk[f];
    end else if (is_ctrl) bus_rdata_o = {7'd0, run_q};
    else if (is_stat)     bus_rdata_o = status;
    else if (is_ien)      bus_rdata_o = {4'd0, ien_q[1], ien_q[0], 2'd0};
  end

  AST_BUSY_LEADS_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cal_pk[F_SEC] != $past(cal_pk[F_SEC])) && !$past(time_wr)) |-> $past(busy)); // R5
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!run_q) && !$past(time_wr)) |-> (cal_pk[F_SEC] == $past(cal_pk[F_SEC]))); // R3
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_flag_q && !(stat_wr && bus_wdata_i[ST_ALARM])) |=> alm_flag_q); // R9
  AST_TIMER_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_timer_o |-> $past(ien_q[0])); // R11
  AST_TIMER_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_timer_o |=> !irq_timer_o); // R11
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = 8'h00;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       irq_timer_o, irq_alarm_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 0;
  bit  timer_seen;

  always #5 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      timer_seen |= irq_timer_o;
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // one full second: set time, step, compare everything
  task automatic run_case(input int s, input int mi, input int h, input int d,
                          input int mo, input int y, input int w,
                          input int amode, input bit en_t, input bit en_a);
    logic [7:0] e [7];
    logic [7:0] a [6];
    logic [7:0] v;
    bit em, eh, ed, hit;
    int ns, nmi, nh, nd, nmo, ny, nw;
    ns = s + 1; nmi = mi; nh = h; nd = d; nmo = mo; ny = y; nw = w;
    em = 0; eh = 0; ed = 0;
    if (ns == 60) begin
      ns = 0; nmi++; em = 1;
      if (nmi == 60) begin
        nmi = 0; nh++; eh = 1;
        if (nh == 24) begin
          nh = 0; ed = 1; nd++; nw = (nw + 1) % 7;
          if (nd > dim(mo, y)) begin
            nd = 1; nmo++;
            if (nmo == 13) begin nmo = 1; ny = (ny + 1) % 100; end
          end
        end
      end
    end
    e[0] = bcd(ns); e[1] = bcd(nmi); e[2] = bcd(nh); e[3] = bcd(nd);
    e[4] = bcd(nmo); e[5] = bcd(ny); e[6] = bcd(nw);
    for (int k = 0; k < 6; k++) a[k] = e[k];
    hit = (amode == 0);
    if (amode == 1) begin
      int k;
      k = $urandom % 6;
      a[k] = a[k] ^ 8'h01;
    end
    wr(8'h48, {4'd0, en_a, en_t, 2'd0});
    wr(8'h40, 8'h01);
    wr(8'h00, bcd(s)); wr(8'h04, bcd(mi)); wr(8'h08, bcd(h)); wr(8'h0C, bcd(d));
    wr(8'h10, bcd(mo)); wr(8'h14, bcd(y)); wr(8'h18, bcd(w));
    for (int k = 0; k < 6; k++) wr(8'(8'h20 + 4 * k), a[k]);
    wr(8'h44, 8'h40);
    tick_n(TPS - 1);
    rd(8'h44, v); chk("R5 busy before update", v & 8'h03, 8'h03);
    rd(8'h00, v); chk("R4 no early update", v, bcd(s));
    timer_seen = 0;
    tick_n(1);
    rd(8'h00, v); chk("R6 sec", v, e[0]);
    rd(8'h04, v); chk("R6 min", v, e[1]);
    rd(8'h08, v); chk("R6 hour", v, e[2]);
    rd(8'h0C, v); chk("R7 day", v, e[3]);
    rd(8'h10, v); chk("R7 month", v, e[4]);
    rd(8'h14, v); chk("R7 year", v, e[5]);
    rd(8'h18, v); chk("R7 weekday", v, e[6]);
    rd(8'h44, v);
    chk("R5 busy clear after update", v & 8'h01, 8'h00);
    chk("R8 event bits", (v >> 2) & 8'h0F, {4'd0, ed, eh, em, 1'b1});
    chk(hit ? "R9 alarm set" : "R12 no partial match", (v >> 6) & 8'h01, {7'd0, hit});
    chk("R11 timer pulse", {7'd0, timer_seen}, {7'd0, en_t});
    chk("R10 alarm irq", {7'd0, irq_alarm_o}, {7'd0, hit & en_a});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 sec", v, 8'h00);
    rd(8'h04, v); chk("R1 min", v, 8'h00);
    rd(8'h08, v); chk("R1 hour", v, 8'h00);
    rd(8'h0C, v); chk("R1 day", v, 8'h01);
    rd(8'h10, v); chk("R1 month", v, 8'h01);
    rd(8'h14, v); chk("R1 year", v, 8'h00);
    rd(8'h18, v); chk("R1 weekday", v, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h00);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);
    chk("R1 irq outputs", {6'd0, irq_timer_o, irq_alarm_o}, 8'h00);

    // R2 masks and map
    wr(8'h00, 8'hDA); rd(8'h00, v); chk("R2 sec mask", v, 8'h5A);
    wr(8'h08, 8'hFF); rd(8'h08, v); chk("R2 hour mask", v, 8'h3F);
    wr(8'h18, 8'hFF); rd(8'h18, v); chk("R2 weekday mask", v, 8'h07);
    wr(8'h30, 8'hFF); rd(8'h30, v); chk("R2 alarm month mask", v, 8'h1F);
    wr(8'h34, 8'h99); rd(8'h34, v); chk("R2 alarm year", v, 8'h99);
    wr(8'h48, 8'hFF); rd(8'h48, v); chk("R2 ien mask", v, 8'h0C);
    wr(8'h48, 8'h00);
    rd(8'h3C, v); chk("R2 unmapped", v, 8'h00);
    rd(8'h01, v); chk("R2 unaligned", v, 8'h00);
    wr(8'h40, 8'hFF); rd(8'h40, v); chk("R2 ctrl mask", v, 8'h01);
    rd(8'h44, v); chk("R3 run mirror", v & 8'h02, 8'h02);

    // R3 stopped clock holds
    wr(8'h40, 8'h00);
    wr(8'h00, 8'h30);
    tick_n(2 * TPS);
    rd(8'h00, v); chk("R3 frozen", v, 8'h30);
    rd(8'h44, v); chk("R3 run/busy low", v & 8'h03, 8'h00);

    // R4 restart by time write
    wr(8'h40, 8'h01);
    wr(8'h00, 8'h10);
    tick_n(3);
    wr(8'h00, 8'h20);
    tick_n(TPS - 1);
    rd(8'h00, v); chk("R4 restart holds", v, 8'h20);
    tick_n(1);
    rd(8'h00, v); chk("R4 restart update", v, 8'h21);
    tick_n(TPS);
    rd(8'h00, v); chk("R4 period", v, 8'h22);

    // directed boundaries R6 R7
    run_case(59, 59, 23, 31, 12, 99, 6, 0, 1, 1);
    run_case(59, 59, 23, 28, 2, 4, 2, 1, 1, 0);
    run_case(59, 59, 23, 28, 2, 3, 5, 0, 0, 1);
    run_case(59, 59, 23, 29, 2, 0, 0, 1, 0, 0);
    run_case(59, 59, 23, 28, 2, 0, 1, 0, 1, 1);
    run_case(59, 59, 23, 28, 2, 10, 3, 1, 1, 1);
    run_case(59, 59, 23, 28, 2, 12, 4, 0, 0, 0);
    run_case(59, 59, 23, 30, 4, 21, 6, 0, 1, 1);
    run_case(59, 59, 23, 30, 11, 50, 2, 1, 0, 1);
    run_case(59, 59, 22, 15, 7, 33, 3, 0, 1, 1);
    run_case(9, 0, 0, 1, 1, 0, 0, 0, 1, 1);

    // R9 write 0 keeps flag, write 1 clears
    wr(8'h44, 8'h00); rd(8'h44, v); chk("R9 write0 ignored", v & 8'h40, 8'h40);
    chk("R10 irq held", {7'd0, irq_alarm_o}, 8'h01);
    wr(8'h44, 8'hBF); rd(8'h44, v); chk("R9 other bits ignored", v & 8'h40, 8'h40);
    wr(8'h44, 8'h40); rd(8'h44, v); chk("R9 clear", v & 8'h40, 8'h00);
    chk("R10 irq cleared", {7'd0, irq_alarm_o}, 8'h00);

    // constrained random
    for (int it = 0; it < 250; it++) begin
      int s, mi, h, d, mo, y, w;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mo = 1 + $urandom % 12;
      y  = $urandom % 100;
      d  = ($urandom % 2) ? dim(mo, y) : 1 + $urandom % dim(mo, y);
      w  = $urandom % 7;
      run_case(s, mi, h, d, mo, y, w, $urandom % 2, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule